// File: doc/BRIEF.md
# Interrupt Status And Mask Unit

This unit collects single-cycle event pulses from a serial bus controller into a sticky pending register and decides which of them may raise the controller's one interrupt line. Each of ten event positions has a pending bit and a permission bit. Software looks at the pending bits through a small register-access port. It acknowledges them by writing back the value it read, because a 1 clears a bit and a 0 leaves it alone. Permission bits are never written directly. Software turns them on through a set-only address and off through a clear-only address, so an update never needs a read-modify-write.

The interrupt line is a flop. It is high in the cycle after any pending bit whose permission bit is also 1. Bit 8 and every position above 9 are reserved. The event positions are: 0 transfer done, 1 data threshold reached, 2 address or data not acknowledged, 3 bus timeout, 4 target ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 9 arbitration lost. Positions 2, 5, 6, 7 and 9 make up the error group.

Top module: `irq_unit`

## Requirements
- R1: After synchronous reset, the pending and permission registers read as zero and irq_o is low.
- R2: An event pulse on an implemented position sets that pending bit at the next clock edge. The bit stays set until software clears it.
- R3: A write to address 0 clears each pending bit whose write-data bit is 1. Pending bits written with 0 keep their value.
- R4: When an event on a position arrives in the same cycle as a clear of that position, the event wins and the bit stays set.
- R5: A write to address 2 sets each permission bit whose write-data bit is 1. Permission bits written with 0 keep their value.
- R6: A write to address 3 clears each permission bit whose write-data bit is 1. Permission bits written with 0 keep their value.
- R7: A read of address 0 returns the pending bits and a read of address 1 returns the permission bits, both in bits 9:0. A read of address 2, 3 or any other address returns zero. A write to address 1 or to addresses 4 to 7 has no effect. acc_rdata is zero whenever no read is requested.
- R8: Bit 8 and bits 31:10 always read as zero in both registers. Events and writes on those positions are ignored.
- R9: irq_o in a cycle equals the OR over all positions of pending AND permission as held in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | Register access request this cycle |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 3 | Register select: 0 pending, 1 permission view, 2 set permission, 3 clear permission |
| acc_wdata | input | 32 | Write data, one bit per event position |
| acc_rdata | output | 32 | Read data, combinational from the address and the registers |
| evt_i | input | 10 | Event pulses, one per position |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The unit is first tried with directed patterns. Events arrive while all permissions are off, which separates setting a pending bit from raising the line. Permissions are then turned on one bit at a time with set writes that carry zeros elsewhere, which shows that a set write leaves the zero positions alone. Clear writes follow that name only some of the set bits, which shows per-bit acknowledge as opposed to a whole-register wipe. A clear that collides with a fresh event on the same position shows which one has priority. Reserved positions, write-only addresses and the read-only permission view are all written and read back. The run ends with a long stretch of random reads, writes and events, with a reference model compared on every clock.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

    localparam int EVT_W = 10;

    // positions that carry a real event; bit 8 is reserved
    localparam logic [EVT_W-1:0] IMPL_BITS = 10'b10_1111_1111;

    typedef enum logic [2:0] {
        SEL_PENDING = 3'd0,
        SEL_PERMIT  = 3'd1,
        SEL_SET     = 3'd2,
        SEL_CLEAR   = 3'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_unit_pkg::*;
#(
    parameter int              W    = EVT_W,
    parameter logic [W-1:0]    IMPL = IMPL_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_live
            logic pend_q;
            always_ff @(posedge clk) begin
                if (rst)
                    pend_q <= 1'b0;
                else if (evt_i[i])
                    pend_q <= 1'b1;
                else if (clr_i[i])
                    pend_q <= 1'b0;
            end
            assign stat_o[i] = pend_q;
        end else begin : g_tied
            logic unused_in;
            assign unused_in = evt_i[i] ^ clr_i[i];
            assign stat_o[i] = 1'b0;
        end
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        (|(evt_i & IMPL)) |=> ((stat_o & $past(evt_i & IMPL)) == $past(evt_i & IMPL))); // R2

    AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ((~stat_o & $past(stat_o) & ~$past(clr_i)) == '0)); // R3

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (|(evt_i & clr_i & IMPL)) |=> ((stat_o & $past(evt_i & clr_i & IMPL)) == $past(evt_i & clr_i & IMPL))); // R4

    AST_PEND_RSVD: assert property (@(posedge clk) disable iff (rst)
        ((stat_o & ~IMPL) == '0)); // R8

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_unit_pkg::*;
#(
    parameter int              W    = EVT_W,
    parameter logic [W-1:0]    IMPL = IMPL_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] mask_o
);

    logic [W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else
            mask_q <= (mask_q | set_i) & ~clr_i & IMPL;
    end

    assign mask_o = mask_q;

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((mask_q & $past(set_i & IMPL)) == $past(set_i & IMPL))); // R5

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (|clr_i) |=> ((mask_q & $past(clr_i)) == '0)); // R6

    AST_UNNAMED_STABLE: assert property (@(posedge clk) disable iff (rst)
        (((mask_q ^ $past(mask_q)) & ~$past(set_i | clr_i)) == '0)); // R5

    AST_MASK_RSVD: assert property (@(posedge clk) disable iff (rst)
        ((mask_q & ~IMPL) == '0)); // R8

endmodule

// File: rtl/irq_line_stage.sv
module irq_line_stage #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |(stat_i & mask_i);
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/irq_unit.sv
module irq_unit
    import irq_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic [EVT_W-1:0]  evt_i,
    output logic              irq_o
);

    localparam int PAD_W = DATA_W - EVT_W;

    logic             rd_req;
    logic             wr_req;
    logic [EVT_W-1:0] wbits;
    logic [EVT_W-1:0] pend_clr;
    logic [EVT_W-1:0] perm_set;
    logic [EVT_W-1:0] perm_clr;
    logic [EVT_W-1:0] pend;
    logic [EVT_W-1:0] perm;
    logic             unused_wdata;

    assign rd_req       = acc_en & ~acc_wr;
    assign wr_req       = acc_en & acc_wr;
    assign wbits        = acc_wdata[EVT_W-1:0];
    assign unused_wdata = ^acc_wdata[DATA_W-1:EVT_W];

    assign pend_clr = (wr_req && acc_addr == ADDR_W'(SEL_PENDING)) ? wbits : '0;
    assign perm_set = (wr_req && acc_addr == ADDR_W'(SEL_SET))     ? wbits : '0;
    assign perm_clr = (wr_req && acc_addr == ADDR_W'(SEL_CLEAR))   ? wbits : '0;

    irq_status_bank #(.W(EVT_W), .IMPL(IMPL_BITS)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt_i),
        .clr_i  (pend_clr),
        .stat_o (pend)
    );

    irq_mask_bank #(.W(EVT_W), .IMPL(IMPL_BITS)) u_perm (
        .clk    (clk),
        .rst    (rst),
        .set_i  (perm_set),
        .clr_i  (perm_clr),
        .mask_o (perm)
    );

    irq_line_stage #(.W(EVT_W)) u_line (
        .clk    (clk),
        .rst    (rst),
        .stat_i (pend),
        .mask_i (perm),
        .irq_o  (irq_o)
    );

    always_comb begin
        acc_rdata = '0;
        if (rd_req) begin
            if (acc_addr == ADDR_W'(SEL_PENDING))
                acc_rdata = {{PAD_W{1'b0}}, pend};
            else if (acc_addr == ADDR_W'(SEL_PERMIT))
                acc_rdata = {{PAD_W{1'b0}}, perm};
        end
    end

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (rst)
        (|(pend & perm)) |=> irq_o); // R9

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(|(pend & perm)) |=> !irq_o); // R9

    AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_req && (acc_addr == ADDR_W'(SEL_SET) || acc_addr == ADDR_W'(SEL_CLEAR))) |-> (acc_rdata == '0)); // R7

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_req |-> (acc_rdata == '0)); // R7

    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_rdata[DATA_W-1:EVT_W] == '0)); // R8

endmodule

// File: tb/sim_irq_unit.sv
`timescale 1ns/1ps
module sim_irq_unit;

    localparam int DW = 32;
    localparam int AW = 3;
    localparam int EW = 10;
    localparam logic [EW-1:0] KEEP = 10'h2FF;   // R8: bit 8 reserved

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_en = 1'b0;
    logic          acc_wr = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic [DW-1:0] acc_rdata;
    logic [EW-1:0] evt = '0;
    logic          irq;

    always #4 clk = ~clk;

    irq_unit #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .evt_i     (evt),
        .irq_o     (irq)
    );

    logic [EW-1:0] m_stat = '0;
    logic [EW-1:0] m_mask = '0;
    logic          m_irq  = 1'b0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic [EW-1:0] ev, input string tag);
        logic [DW-1:0] er;
        logic [EW-1:0] clr, set, dis;
        @(negedge clk);
        acc_en = en; acc_wr = wr; acc_addr = a; acc_wdata = wd; evt = ev;
        #2;
        er = '0;
        if (en && !wr) begin
            if (a == 3'd0) er = {22'b0, m_stat};
            else if (a == 3'd1) er = {22'b0, m_mask};
        end
        chk(tag, "rdata", acc_rdata, er);
        chk(tag, "irq", {31'b0, irq}, {31'b0, m_irq});
        @(posedge clk);
        clr = (en && wr && a == 3'd0) ? wd[EW-1:0] : '0;
        set = (en && wr && a == 3'd2) ? wd[EW-1:0] : '0;
        dis = (en && wr && a == 3'd3) ? wd[EW-1:0] : '0;
        m_irq  = |(m_stat & m_mask);
        m_stat = ((m_stat & ~clr) | ev) & KEEP;
        m_mask = ((m_mask | set) & ~dis) & KEEP;
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        step(1'b1, 1'b0, a, '0, '0, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        step(1'b1, 1'b1, a, d, '0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(3'd0, "R1 pending after reset");
        rd(3'd1, "R1 permission after reset");
        step(1'b0, 1'b0, 3'd0, '0, 10'h205, "R2 events, line masked");
        rd(3'd0, "R2 pending set");
        step(1'b0, 1'b0, 3'd0, '0, '0, "R9 masked line low");
        wr(3'd2, 32'h004, "R5 set permission 2");
        rd(3'd1, "R5 permission view");
        wr(3'd2, 32'h001, "R5 zeros keep permission");
        rd(3'd1, "R5 permission accumulate");
        rd(3'd2, "R7 set address reads zero");
        rd(3'd3, "R7 clear address reads zero");
        wr(3'd3, 32'h004, "R6 clear permission 2");
        rd(3'd1, "R6 permission after clear");
        wr(3'd0, 32'h001, "R3 acknowledge bit 0");
        rd(3'd0, "R3 other bits kept");
        step(1'b0, 1'b0, 3'd0, '0, '0, "R9 line falls");
        step(1'b0, 1'b0, 3'd0, '0, 10'h100, "R8 reserved event");
        wr(3'd2, 32'hFFFF_FFFF, "R8 set all permissions");
        rd(3'd1, "R8 reserved permission zero");
        rd(3'd0, "R8 reserved pending zero");
        step(1'b1, 1'b1, 3'd0, 32'h200, 10'h200, "R4 event beats clear");
        rd(3'd0, "R4 bit 9 still set");
        wr(3'd1, 32'h000, "R7 permission view write ignored");
        rd(3'd1, "R7 permission unchanged");
        wr(3'd5, 32'h3FF, "R7 unused address write ignored");
        rd(3'd5, "R7 unused address reads zero");
        wr(3'd0, 32'h3FF, "R3 acknowledge all");
        rd(3'd0, "R3 pending empty");
        for (int k = 0; k < 600; k++) begin
            logic [EW-1:0] ev;
            ev = EW'($urandom & $urandom & $urandom);
            step(1'($urandom), 1'($urandom), AW'($urandom % 6), $urandom, ev, "R9 random mix");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule